// File: doc/BRIEF.md
# Synchronous Burst SRAM Read/Write Pipeline

This block models a small synchronous static memory whose address, control and write data are all captured on the rising clock edge. An access begins with one of two address strobes. A two-bit burst counter then supplies up to four addresses in either linear or interleaved order. Between strobes, an advance input steps the counter, or holds it so the same location is accessed again. Writes either cover every byte lane at once, or only the lanes picked by per-lane enables.

Read data leaves through one of two paths, chosen by a mode input. The flow-through path feeds the array output straight out. The pipelined path adds one output register. When the chip is deselected, the output is switched off one stage earlier than read data travels. Output enable and sleep act without waiting for a clock. A separate data-valid flag stands in for a driven bus. While the flag is low, the data output reads as zero, which models high impedance.

Top module: `sbs_sram`

## Requirements
- R1: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe edge while unselected is a deselect. It writes nothing, starts no read and ends any running burst.
- R2: A write cycle with `all_wr_n`=0 writes every lane of `wdata`, whatever `lane_wr_n` and `lane_en_n` hold.
- R3: With `all_wr_n`=1 and `lane_wr_n`=0, only the lanes whose `lane_en_n` bit is 0 are written. Bit i covers `wdata[8i+7:8i]`. With `lane_wr_n`=1, or with no lane enabled, the cycle is a read.
- R4: A start on `strobe_p_n` is always a read and never changes memory. A start on `strobe_c_n` alone, with R2/R3 write controls active, writes `wdata` sampled at that same edge to `addr`. A write cycle produces no read data.
- R5: For burst beat k (0..3) from start address a, the upper address bits stay fixed. The low two bits are (a+k) mod 4 when `lin_order_n`=0, and a XOR k when `lin_order_n`=1.
- R6: On an edge with both strobes high during a burst, `advance_n`=0 moves to the next beat and `advance_n`=1 repeats the current address. Either case reads or writes as the write controls select.
- R7: With `pipe_sel`=0, a read captured at edge N shows `rvalid`=1 and the word in the cycle between edges N and N+1.
- R8: With `pipe_sel`=1, a read captured at edge N shows in the cycle between edges N+1 and N+2, and not before.
- R9: After an edge that captures a deselect, `rvalid` is 0 in the next cycle in both modes. In pipelined mode this also holds for a read captured one edge earlier.
- R10: `out_en_n`=1 forces `rvalid`=0 at once, with no clock edge needed. Returning it to 0 restores the pending word. Whenever `rvalid`=0, `rdata` is all zeros.
- R11: `doze`=1 drops `rvalid` at once. Strobes, advances and writes at edges during doze are ignored, and stored data is kept. The first edge after release behaves normally. Reads pending when doze began are discarded.
- R12: During and right after reset, `rvalid`=0, `rdata`=0 and no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | AW | Start address, used on strobe edges |
| strobe_p_n | input | 1 | Processor-side strobe, active low, read-only start |
| strobe_c_n | input | 1 | Controller-side strobe, active low, read or write start |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Lane-selective write, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LW | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Asynchronous sleep, active high |
| pipe_sel | input | 1 | 1 = pipelined output, 0 = flow-through |
| lin_order_n | input | 1 | 0 = linear burst order, 1 = interleaved |
| rdata | output | LANES*LW | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
A vector table of single-cycle writes mixes the all-lanes write, each single lane, both lanes, no lanes, the lane write disabled, and writes attempted under the processor strobe. Reading every address back separates the override of R2 from the lane masking of R3 and from the read-only start. Four-beat bursts from an unaligned address in both orders, in both output modes, tell linear from interleaved wrap. They also show the one-cycle latency difference between the paths. A suspend beat, a deselect straight after a pipelined read, and toggling output enable, doze and each chip select separate the asynchronous turn-off from the clocked pipeline.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Low two address bits of burst beat k from start offset s.
  function automatic logic [1:0] beat_low(input logic [1:0] s, input logic [1:0] k,
                                          input logic linear);
    return linear ? 2'(s + k) : (s ^ k);
  endfunction

  // All three chip selects asserted.
  function automatic logic chip_sel(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen import sbs_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          start,
  input  logic          desel,
  input  logic          adv,
  input  logic          linear,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] eff_addr,
  output logic          active
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          act_q;
  logic [1:0]    beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (hold || desel) begin
      act_q  <= 1'b0;
    end else if (start) begin
      act_q  <= 1'b1;
      base_q <= addr_in;
      cnt_q  <= 2'd0;
    end else if (act_q && adv) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  always_comb begin
    beat = adv ? 2'(cnt_q + 2'd1) : cnt_q;
    if (start) eff_addr = addr_in;
    else       eff_addr = {base_q[AW-1:2], beat_low(base_q[1:0], beat, linear)};
  end

  assign active = act_q;

  // R5
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hold && !desel) |=> (act_q && cnt_q == 2'd0));
  // R6
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && adv && !start && !desel && !hold) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));
  // R6
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !adv && !start && !desel && !hold) |=> $stable(cnt_q));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) cells[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = cells[raddr];
  end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          doze,
  input  logic          rd_ev,
  input  logic          desel_ev,
  input  logic [AW-1:0] rd_addr_in,
  input  logic [DW-1:0] core_data,
  input  logic          pipe_sel,
  input  logic          out_en_n,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          act1_q, act2_q, dsl_q;
  logic [DW-1:0] dq_q;
  logic          core_vld;
  logic [DW-1:0] core_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act1_q <= 1'b0;
      act2_q <= 1'b0;
      dsl_q  <= 1'b0;
      raddr  <= '0;
      dq_q   <= '0;
    end else if (doze) begin
      act1_q <= 1'b0;
      act2_q <= 1'b0;
      dsl_q  <= 1'b0;
    end else begin
      act1_q <= rd_ev;
      if (rd_ev) raddr <= rd_addr_in;
      act2_q <= act1_q;
      dq_q   <= core_data;
      dsl_q  <= desel_ev;
    end
  end

  always_comb begin
    core_vld = pipe_sel ? (act2_q && !dsl_q) : act1_q;
    core_out = pipe_sel ? dq_q : core_data;
    rvalid   = core_vld && !out_en_n && !doze;
    rdata    = rvalid ? core_out : '0;
  end

  // R8
  pipe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_sel && rvalid) |-> $past(act1_q));
  // R9
  scd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_ev |=> !rvalid);
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram import sbs_pkg::*; #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                strobe_p_n,
  input  logic                strobe_c_n,
  input  logic                advance_n,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                all_wr_n,
  input  logic                lane_wr_n,
  input  logic [LANES-1:0]    lane_en_n,
  input  logic [LANES*LW-1:0] wdata,
  input  logic                out_en_n,
  input  logic                doze,
  input  logic                pipe_sel,
  input  logic                lin_order_n,
  output logic [LANES*LW-1:0] rdata,
  output logic                rvalid
);
  localparam int DW = LANES * LW;

  logic          chip_on, any_strobe, burst_on;
  logic          ev_desel, ev_start, ev_cont, ev_adv, wr_want, ev_wr, ev_rd;
  logic [AW-1:0] acc_addr, rd_addr;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0] core_q;

  assign chip_on    = chip_sel(sel_a_n, sel_b, sel_c_n);
  assign any_strobe = !strobe_p_n || !strobe_c_n;
  assign ev_desel   = !doze && any_strobe && !chip_on;
  assign ev_start   = !doze && any_strobe && chip_on;
  assign ev_cont    = !doze && !any_strobe && burst_on;
  assign ev_adv     = ev_cont && !advance_n;
  assign wr_want    = !all_wr_n || (!lane_wr_n && (lane_en_n != '1));
  assign ev_wr      = wr_want && ((ev_start && strobe_p_n) || ev_cont);
  assign ev_rd      = (ev_start || ev_cont) && !ev_wr;

  always_comb begin
    lane_we = '0;
    if (ev_wr) lane_we = all_wr_n ? ~lane_en_n : '1;
  end

  sbs_burst_gen #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .hold(doze), .start(ev_start), .desel(ev_desel),
    .adv(ev_adv), .linear(!lin_order_n), .addr_in(addr),
    .eff_addr(acc_addr), .active(burst_on)
  );

  sbs_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .we(lane_we), .waddr(acc_addr), .wdata(wdata),
    .raddr(rd_addr), .rdata(core_q)
  );

  sbs_out_stage #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .doze(doze), .rd_ev(ev_rd), .desel_ev(ev_desel),
    .rd_addr_in(acc_addr), .core_data(core_q), .pipe_sel(pipe_sel),
    .out_en_n(out_en_n), .raddr(rd_addr), .rdata(rdata), .rvalid(rvalid)
  );

  // R4
  proc_strobe_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_p_n |-> (lane_we == '0));
  // R11
  doze_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> (lane_we == '0));
endmodule

// File: tb/sbs_sram_tb.sv
module sbs_sram_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic strobe_p_n = 1, strobe_c_n = 1, advance_n = 1;
  logic sel_a_n = 0, sel_b = 1, sel_c_n = 0;
  logic all_wr_n = 1, lane_wr_n = 1;
  logic [1:0] lane_en_n = '1;
  logic [15:0] wdata = '0;
  logic out_en_n = 0, doze = 0, pipe_sel = 0, lin_order_n = 0;
  logic [15:0] rdata;
  logic rvalid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] ref_mem [64];

  always #2 clk = ~clk;

  sbs_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .advance_n(advance_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n), .wdata(wdata),
    .out_en_n(out_en_n), .doze(doze), .pipe_sel(pipe_sel), .lin_order_n(lin_order_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  // {addr, data, all_wr_n, lane_wr_n, lane_en_n, use processor strobe}
  localparam logic [26:0] VEC [10] = '{
    {6'd1,  16'h1234, 1'b0, 1'b1, 2'b11, 1'b0},
    {6'd2,  16'h5678, 1'b0, 1'b0, 2'b10, 1'b0},
    {6'd3,  16'h9ABC, 1'b1, 1'b0, 2'b10, 1'b0},
    {6'd4,  16'hDEF0, 1'b1, 1'b0, 2'b01, 1'b0},
    {6'd5,  16'h0F0F, 1'b1, 1'b0, 2'b00, 1'b0},
    {6'd6,  16'hFFFF, 1'b1, 1'b0, 2'b11, 1'b0},
    {6'd7,  16'h4242, 1'b1, 1'b1, 2'b00, 1'b0},
    {6'd8,  16'h7777, 1'b0, 1'b1, 2'b11, 1'b1},
    {6'd9,  16'h3C3C, 1'b1, 1'b0, 2'b00, 1'b1},
    {6'd10, 16'hAAAA, 1'b0, 1'b1, 2'b11, 1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    strobe_p_n = 1; strobe_c_n = 1; advance_n = 1;
    all_wr_n = 1; lane_wr_n = 1; lane_en_n = '1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
  endtask

  task automatic go_desel();
    go_idle();
    strobe_c_n = 0;
    sel_a_n = 1;
  endtask

  task automatic go_start(input logic [5:0] a, input logic proc, input logic g,
                          input logic b, input logic [1:0] ln, input logic [15:0] d);
    go_idle();
    addr = a;
    if (proc) strobe_p_n = 0; else strobe_c_n = 0;
    all_wr_n = g; lane_wr_n = b; lane_en_n = ln; wdata = d;
  endtask

  task automatic go_cont(input logic adv, input logic g, input logic [15:0] d);
    go_idle();
    advance_n = !adv; all_wr_n = g; wdata = d;
  endtask

  task automatic read_chk(input logic [5:0] a, input string tag);
    go_start(a, 0, 1, 1, 2'b11, 16'h0);
    tick();
    chk({tag, " valid"}, 32'(rvalid), 32'd1);
    chk({tag, " data"}, 32'(rdata), 32'(ref_mem[a]));
    go_desel();
    tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    go_idle();
    repeat (3) tick();
    chk("R12 reset rvalid", 32'(rvalid), 32'd0);
    chk("R12 reset rdata", 32'(rdata), 32'd0);
    rst_n = 1;
    go_desel();
    tick();
    chk("R12 post-reset rvalid", 32'(rvalid), 32'd0);

    // prefill 0..31 with all-lane writes, flow-through
    for (int a = 0; a < 32; a++) begin
      logic [15:0] pat;
      pat = 16'hC000 | (16'(a) << 8) | 16'(8'h3C ^ 8'(a));
      go_start(6'(a), 0, 0, 1, 2'b11, pat);
      ref_mem[a] = pat;
      tick();
    end
    go_desel();
    tick();

    // table of single-cycle write attempts (R2, R3, R4)
    for (int i = 0; i < 10; i++) begin
      logic [5:0] va; logic [15:0] vd; logic vg, vb, vp; logic [1:0] vl;
      {va, vd, vg, vb, vl, vp} = VEC[i];
      go_start(va, vp, vg, vb, vl, vd);
      tick();
      if (!vp) begin
        if (!vg) ref_mem[va] = vd;
        else if (!vb)
          for (int j = 0; j < 2; j++)
            if (!vl[j]) ref_mem[va][j*8 +: 8] = vd[j*8 +: 8];
      end
      go_desel();
      tick();
    end
    for (int i = 0; i < 10; i++)
      read_chk(6'(i + 1), $sformatf("R2 R3 R4 vec %0d", i));

    // linear and interleaved flow-through bursts from address 17
    for (int m = 0; m < 2; m++) begin
      lin_order_n = 1'(m);
      chk("R7 idle before read", 32'(rvalid), 32'd0);
      go_start(6'd17, 0, 1, 1, 2'b11, 16'h0);
      for (int k = 0; k < 4; k++) begin
        int exp_a;
        exp_a = (m == 0) ? 16 + ((1 + k) % 4) : 16 + (1 ^ k);
        tick();
        chk($sformatf("R5 R7 mode %0d beat %0d valid", m, k), 32'(rvalid), 32'd1);
        chk($sformatf("R5 R7 mode %0d beat %0d data", m, k), 32'(rdata), 32'(ref_mem[exp_a]));
        go_cont(1, 1, 16'h0);
      end
      go_desel();
      tick();
      chk("R9 flow deselect", 32'(rvalid), 32'd0);
    end
    lin_order_n = 0;

    // suspend then advance
    go_start(6'd18, 0, 1, 1, 2'b11, 16'h0);
    tick();
    chk("R6 beat0", 32'(rdata), 32'(ref_mem[18]));
    go_cont(0, 1, 16'h0);
    tick();
    chk("R6 suspend repeats", 32'(rdata), 32'(ref_mem[18]));
    go_cont(1, 1, 16'h0);
    tick();
    chk("R6 advance after suspend", 32'(rdata), 32'(ref_mem[19]));
    go_desel();
    tick();

    // pipelined burst and single-cycle deselect cut-off
    pipe_sel = 1;
    tick();
    go_start(6'd17, 0, 1, 1, 2'b11, 16'h0);
    tick();
    chk("R8 no data one cycle after capture", 32'(rvalid), 32'd0);
    for (int k = 0; k < 4; k++) begin
      if (k < 3) go_cont(1, 1, 16'h0); else go_cont(0, 1, 16'h0);
      tick();
      chk($sformatf("R8 pipe beat %0d valid", k), 32'(rvalid), 32'd1);
      chk($sformatf("R8 pipe beat %0d data", k), 32'(rdata), 32'(ref_mem[16 + ((1 + k) % 4)]));
    end
    go_desel();
    tick();
    chk("R9 pipelined deselect cuts pending read", 32'(rvalid), 32'd0);
    tick();
    pipe_sel = 0;

    // burst write from 22 (linear: 22,23,20,21)
    go_start(6'd22, 0, 0, 1, 2'b11, 16'h1111);
    tick();
    chk("R4 write cycle no read data", 32'(rvalid), 32'd0);
    ref_mem[22] = 16'h1111;
    for (int k = 1; k < 4; k++) begin
      logic [15:0] d;
      d = 16'(16'h1111 * (k + 1));
      go_cont(1, 0, d);
      ref_mem[20 + ((2 + k) % 4)] = d;
      tick();
    end
    go_desel();
    tick();
    for (int a = 20; a < 24; a++)
      read_chk(6'(a), $sformatf("R6 burst write addr %0d", a));

    // asynchronous output enable
    go_start(6'd5, 0, 1, 1, 2'b11, 16'h0);
    tick();
    chk("R10 read valid", 32'(rvalid), 32'd1);
    out_en_n = 1;
    go_cont(0, 1, 16'h0);
    #1;
    chk("R10 oe off rvalid", 32'(rvalid), 32'd0);
    chk("R10 oe off rdata zero", 32'(rdata), 32'd0);
    tick();
    out_en_n = 0;
    #1;
    chk("R10 oe restored valid", 32'(rvalid), 32'd1);
    chk("R10 oe restored data", 32'(rdata), 32'(ref_mem[5]));

    // doze: immediate turn-off, writes ignored, contents kept
    tick();
    doze = 1;
    go_start(6'd5, 0, 0, 1, 2'b11, 16'hBEEF);
    #1;
    chk("R11 doze drops rvalid", 32'(rvalid), 32'd0);
    tick();
    tick();
    doze = 0;
    go_start(6'd5, 0, 1, 1, 2'b11, 16'h0);
    #1;
    chk("R11 pending read discarded", 32'(rvalid), 32'd0);
    tick();
    chk("R11 resumes valid", 32'(rvalid), 32'd1);
    chk("R11 contents kept", 32'(rdata), 32'(ref_mem[5]));
    go_desel();
    tick();

    // each chip select alone blocks the access
    for (int c = 0; c < 3; c++) begin
      go_start(6'd6, 0, 0, 1, 2'b11, 16'(16'hDEA0 + c));
      if (c == 0) sel_a_n = 1;
      if (c == 1) sel_b = 0;
      if (c == 2) sel_c_n = 1;
      tick();
      chk($sformatf("R1 unselected %0d no data", c), 32'(rvalid), 32'd0);
    end
    go_desel();
    tick();
    read_chk(6'd6, "R1 unselected writes dropped");

    done = 1;
    summary();
    $finish;
  end
endmodule